// File: doc/BRIEF.md
# GF(2) Matrix-Vector Stream Multiplier

This block multiplies one row of a square matrix over GF(2) by a stream of M column vectors of length N. It yields one result element per vector. Each element is a W-bit word of W independent GF(2) lanes, so a product is a bitwise AND and a sum is a bitwise XOR. The row is first written, element by element, into an internal row buffer. Vector elements are then streamed through a single multiply-accumulate path.

The stream is interleaved. Element 0 of vectors 0..M-1 is presented first, then element 1 of all M vectors, and so on up to element N-1. The partial sums of the M vectors in flight circulate through a delay line whose depth is M. This lets a single AND/XOR datapath serve all of them.

At the first element of a pass, the accumulator starts from zero. It can instead start from a partial sum supplied by a previous identical stage, so that several stages can be chained. After the last element, each vector's result leaves on a registered output with a valid strobe, in the order the vectors entered.

Top module: `gf2_mv_stream`

## Requirements
- R1: While `rst` is high, and after it falls, `out_valid` is 0. The row buffer holds all zeros. The load position is 0, and the stream position is element 0 of vector 0.
- R2: A beat with `in_valid`=1 and `in_cmd`=0 (load) writes `in_data` into the row buffer at the load position. The load position then advances 0,1,..,N-1 and wraps to 0.
- R3: A beat with `in_valid`=1 and `in_cmd`=1 (stream) carries element j of vector v. Successive stream beats run over v=0..M-1 for j=0, then for j=1, and so on. After M*N beats the next pass restarts at j=0, v=0. Load beats do not move the stream position.
- R4: For each vector the result equals the XOR over j of (row[j] AND V[j]), when the cascade select is 0 at that vector's element-0 beat.
- R5: If `casc_sel`=1 on a vector's element-0 beat, `casc_data` of that beat is XORed into that vector's result. `casc_sel` and `casc_data` on any other beat have no effect.
- R6: `out_valid` is 1 in exactly the cycle after each element-(N-1) stream beat, and at no other time. In that cycle `out_data` holds the result and `out_vec` holds the vector index v. This gives M strobes per pass in vector order.
- R7: A cycle with `in_valid`=0 changes neither the row buffer, nor the positions, nor the partial sums, whatever `in_cmd`, `in_data` and `casc_*` hold.
- R8: The row buffer keeps its contents across passes, so repeated passes without reloading use the same row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input beat present |
| in_cmd | input | 1 | 0 = load row element, 1 = stream vector element |
| in_data | input | W | Row element or vector element |
| casc_sel | input | 1 | Start the accumulation from `casc_data` (element-0 beats only) |
| casc_data | input | W | Partial sum from a previous stage |
| out_valid | output | 1 | Result strobe |
| out_data | output | W | Result element for one vector |
| out_vec | output | max(1,clog2(M)) | Index of the vector the result belongs to |

## Verification
On every cycle, the assertions check the following:
- the element and vector position counters step in interleaved order and wrap at the end of a pass;
- idle and load beats leave the stream position alone;
- the load position wraps;
- a written row entry holds the written value;
- the delay line freezes without a stream beat;
- a result strobe appears exactly after a last-element beat.

The arithmetic itself cannot be seen by a property, and only the bench scenarios can show it. This covers:
- the XOR-of-ANDs result per vector;
- the cascade value being taken at element 0 and ignored elsewhere;
- row reuse across passes;
- overwriting on a wrapped reload;
- a reset in the middle of a pass leaving no stale partial sums.

// File: rtl/mvs_pkg.sv
package mvs_pkg;

    typedef enum logic {
        CMD_LOAD   = 1'b0,
        CMD_STREAM = 1'b1
    } cmd_e;

    typedef struct packed {
        logic load;
        logic stream;
        logic first;
        logic last;
    } step_t;

    function automatic int idx_width(input int count);
        return (count > 1) ? $clog2(count) : 1;
    endfunction

endpackage

// File: rtl/mvs_ctrl.sv
module mvs_ctrl
    import mvs_pkg::*;
#(
    parameter int N = 4,
    parameter int M = 3,
    localparam int EW = idx_width(N),
    localparam int VW = idx_width(M)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  cmd_e          cmd,
    output step_t         ctl,
    output logic [EW-1:0] ld_idx,
    output logic [EW-1:0] el_idx,
    output logic [VW-1:0] vec_idx
);

    localparam logic [EW-1:0] EL_LAST  = EW'(N - 1);
    localparam logic [VW-1:0] VEC_LAST = VW'(M - 1);

    always_comb begin
        ctl.load   = in_valid && (cmd == CMD_LOAD);
        ctl.stream = in_valid && (cmd == CMD_STREAM);
        ctl.first  = (el_idx == '0);
        ctl.last   = (el_idx == EL_LAST);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ld_idx  <= '0;
            el_idx  <= '0;
            vec_idx <= '0;
        end else begin
            if (ctl.load) begin
                ld_idx <= (ld_idx == EL_LAST) ? '0 : ld_idx + 1'b1;
            end
            if (ctl.stream) begin
                if (vec_idx == VEC_LAST) begin
                    vec_idx <= '0;
                    el_idx  <= (el_idx == EL_LAST) ? '0 : el_idx + 1'b1;
                end else begin
                    vec_idx <= vec_idx + 1'b1;
                end
            end
        end
    end

    AST_ELEM_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        (ctl.stream && vec_idx == VEC_LAST && el_idx != EL_LAST)
        |=> (el_idx == $past(el_idx) + 1'b1 && vec_idx == '0)); // R3

    AST_PASS_WRAP: assert property (@(posedge clk) disable iff (rst)
        (ctl.stream && vec_idx == VEC_LAST && el_idx == EL_LAST)
        |=> (el_idx == '0 && vec_idx == '0)); // R3

    AST_LOAD_KEEPS_POS: assert property (@(posedge clk) disable iff (rst)
        ctl.load |=> ($stable(el_idx) && $stable(vec_idx))); // R3

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(el_idx) && $stable(vec_idx) && $stable(ld_idx))); // R7

    AST_LOAD_WRAP: assert property (@(posedge clk) disable iff (rst)
        (ctl.load && ld_idx == EL_LAST) |=> (ld_idx == '0)); // R2

endmodule

// File: rtl/mvs_rowbuf.sv
module mvs_rowbuf
    import mvs_pkg::*;
#(
    parameter int W = 8,
    parameter int N = 4,
    localparam int EW = idx_width(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [EW-1:0] wr_idx,
    input  logic [W-1:0]  wr_data,
    input  logic [EW-1:0] rd_idx,
    output logic [W-1:0]  rd_data
);

    logic [W-1:0] ent [N];

    for (genvar g = 0; g < N; g++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst) begin
                ent[g] <= '0;
            end else if (wr_en && wr_idx == EW'(g)) begin
                ent[g] <= wr_data;
            end
        end
    end

    assign rd_data = ent[rd_idx];

    AST_ROW_WRITE: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (ent[$past(wr_idx)] == $past(wr_data))); // R2

endmodule

// File: rtl/mvs_delay.sv
module mvs_delay #(
    parameter int W = 8,
    parameter int M = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         shift_en,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [W-1:0] stage [M];

    for (genvar g = 0; g < M; g++) begin : g_stage
        if (g == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (rst)           stage[g] <= '0;
                else if (shift_en) stage[g] <= din;
            end
        end else begin : g_tail
            always_ff @(posedge clk) begin
                if (rst)           stage[g] <= '0;
                else if (shift_en) stage[g] <= stage[g-1];
            end
        end
    end

    assign dout = stage[M-1];

    AST_DELAY_HOLD: assert property (@(posedge clk) disable iff (rst)
        !shift_en |=> $stable(dout)); // R7

endmodule

// File: rtl/gf2_mv_stream.sv
module gf2_mv_stream
    import mvs_pkg::*;
#(
    parameter int W = 8,
    parameter int N = 4,
    parameter int M = 3,
    localparam int EW = idx_width(N),
    localparam int VW = idx_width(M)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic          in_cmd,
    input  logic [W-1:0]  in_data,
    input  logic          casc_sel,
    input  logic [W-1:0]  casc_data,
    output logic          out_valid,
    output logic [W-1:0]  out_data,
    output logic [VW-1:0] out_vec
);

    cmd_e          cmd;
    step_t         ctl;
    logic [EW-1:0] ld_idx;
    logic [EW-1:0] el_idx;
    logic [VW-1:0] vec_idx;
    logic [W-1:0]  row_elem;
    logic [W-1:0]  dl_out;
    logic [W-1:0]  addend;
    logic [W-1:0]  sum;

    assign cmd = cmd_e'(in_cmd);

    mvs_ctrl #(.N(N), .M(M)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .in_valid(in_valid),
        .cmd     (cmd),
        .ctl     (ctl),
        .ld_idx  (ld_idx),
        .el_idx  (el_idx),
        .vec_idx (vec_idx)
    );

    // Load path of the input mux: row elements go to the buffer.
    mvs_rowbuf #(.W(W), .N(N)) u_row (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (ctl.load),
        .wr_idx (ld_idx),
        .wr_data(in_data),
        .rd_idx (el_idx),
        .rd_data(row_elem)
    );

    // Accumulator source: the delay line, or a cleared/cascaded start at element 0.
    always_comb begin
        if (!ctl.first)    addend = dl_out;
        else if (casc_sel) addend = casc_data;
        else               addend = '0;
        sum = (row_elem & in_data) ^ addend;
    end

    mvs_delay #(.W(W), .M(M)) u_dl (
        .clk     (clk),
        .rst     (rst),
        .shift_en(ctl.stream),
        .din     (sum),
        .dout    (dl_out)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_vec   <= '0;
        end else begin
            out_valid <= ctl.stream && ctl.last;
            if (ctl.stream && ctl.last) begin
                out_data <= sum;
                out_vec  <= vec_idx;
            end
        end
    end

    AST_STROBE_CAUSE: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid && in_cmd && el_idx == EW'(N - 1))); // R6

    AST_STROBE_ON_LAST: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_cmd && el_idx == EW'(N - 1)) |=> out_valid); // R6

endmodule

// File: tb/gf2_mv_stream_test.sv
`timescale 1ns/1ps
module gf2_mv_stream_test;

    localparam int W  = 8;
    localparam int N  = 4;
    localparam int M  = 3;
    localparam int VW = (M > 1) ? $clog2(M) : 1;

    logic          clk = 1'b0;
    logic          rst;
    logic          in_valid;
    logic          in_cmd;
    logic [W-1:0]  in_data;
    logic          casc_sel;
    logic [W-1:0]  casc_data;
    logic          out_valid;
    logic [W-1:0]  out_data;
    logic [VW-1:0] out_vec;

    always #2.5 clk = ~clk;

    gf2_mv_stream #(.W(W), .N(N), .M(M)) uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_cmd(in_cmd),
        .in_data(in_data), .casc_sel(casc_sel), .casc_data(casc_data),
        .out_valid(out_valid), .out_data(out_data), .out_vec(out_vec)
    );

    int n_chk  = 0;
    int n_fail = 0;

    // Bench model, built from the requirements.
    logic [W-1:0] row_m [N];
    logic [W-1:0] acc_m [M];
    int           ld_m, el_m, vec_m;
    logic         pend_v;
    logic [W-1:0] pend_d;
    int           pend_idx;
    string        cur_req = "R4";

    task automatic chk(input bit ok, input string req, input string what,
                       input int got, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s got=%0h exp=%0h at %0t", req, what, got, exp, $time);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < N; i++) row_m[i] = '0;
        for (int i = 0; i < M; i++) acc_m[i] = '0;
        ld_m = 0; el_m = 0; vec_m = 0; pend_v = 1'b0; pend_d = '0; pend_idx = 0;
    endtask

    // One clock: check the previous beat's outcome, then drive a new beat.
    task automatic cycle(input logic v, input logic c, input logic [W-1:0] d,
                         input logic cs, input logic [W-1:0] cd);
        logic [W-1:0] add;
        @(negedge clk);
        chk(out_valid === pend_v, "R6", "out_valid", int'(out_valid), int'(pend_v));
        if (pend_v) begin
            chk(out_data === pend_d, cur_req, "out_data", int'(out_data), int'(pend_d));
            chk(int'(out_vec) == pend_idx, "R6", "out_vec", int'(out_vec), pend_idx);
        end
        in_valid = v; in_cmd = c; in_data = d; casc_sel = cs; casc_data = cd;
        pend_v = 1'b0;
        if (v && !c) begin
            row_m[ld_m] = d;
            ld_m = (ld_m + 1) % N;
        end else if (v && c) begin
            add = (el_m != 0) ? acc_m[vec_m] : (cs ? cd : '0);
            acc_m[vec_m] = (row_m[el_m] & d) ^ add;
            if (el_m == N - 1) begin
                pend_v = 1'b1; pend_d = acc_m[vec_m]; pend_idx = vec_m;
            end
            if (vec_m == M - 1) begin
                vec_m = 0; el_m = (el_m + 1) % N;
            end else begin
                vec_m++;
            end
        end
    endtask

    // R7: idle cycle with junk on every other input.
    task automatic idle_junk();
        cycle(1'b0, 1'($urandom), W'($urandom), 1'($urandom), W'($urandom));
    endtask

    task automatic maybe_gap(input int odds);
        if (odds > 0 && ($urandom % odds) == 0) idle_junk();
    endtask

    task automatic load_elem(input logic [W-1:0] d, input int odds);
        maybe_gap(odds);
        cycle(1'b1, 1'b0, d, 1'($urandom), W'($urandom));
    endtask

    task automatic stream_elem(input logic [W-1:0] d, input logic cs,
                               input logic [W-1:0] cd, input int odds);
        maybe_gap(odds);
        cycle(1'b1, 1'b1, d, cs, cd);
    endtask

    // A whole pass: at element 0, cascade per casc_mode (0 off, 1 on, 2 random);
    // at other elements casc inputs are random junk (R5).
    task automatic run_pass(input int casc_mode, input int odds);
        for (int j = 0; j < N; j++) begin
            for (int v = 0; v < M; v++) begin
                logic cs;
                if (j == 0) cs = (casc_mode == 2) ? 1'($urandom) : (casc_mode == 1);
                else        cs = 1'($urandom);
                stream_elem(W'($urandom), cs, W'($urandom), odds);
            end
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b0;
        repeat (2) @(negedge clk);
        chk(out_valid === 1'b0, "R1", "out_valid in reset", int'(out_valid), 0);
        rst = 1'b0;
        model_reset();
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'd13579));
        rst = 1'b1; in_valid = 1'b0; in_cmd = 1'b0; in_data = '0;
        casc_sel = 1'b0; casc_data = '0;
        model_reset();
        repeat (3) @(negedge clk);
        chk(out_valid === 1'b0, "R1", "out_valid at reset", int'(out_valid), 0);
        rst = 1'b0;

        // R1: row buffer cleared, pass without load gives zero results.
        cur_req = "R1";
        run_pass(0, 0);

        // R4: directed row and vectors.
        cur_req = "R4";
        load_elem(8'hFF, 0); load_elem(8'h0F, 0); load_elem(8'hF0, 0); load_elem(8'h01, 0);
        for (int j = 0; j < N; j++)
            for (int v = 0; v < M; v++)
                stream_elem(W'(8'h11 * (v + 1) + j), 1'b0, 8'hAA, 0);

        // R8: same row reused for a second and third pass.
        cur_req = "R8";
        run_pass(0, 0);
        run_pass(0, 3);

        // R2: 2N loads wrap the load position; the second set wins.
        cur_req = "R2";
        for (int k = 0; k < 2 * N; k++) load_elem(W'($urandom), 0);
        run_pass(0, 0);

        // R5: cascade at element 0, junk cascade elsewhere.
        cur_req = "R5";
        run_pass(1, 0);
        run_pass(2, 4);

        // R7: long idle stretches with junk between beats.
        cur_req = "R7";
        for (int k = 0; k < 5; k++) idle_junk();
        run_pass(0, 2);

        // R3: loads in the middle of a pass do not move the stream position
        // (rewrites the element already consumed, with the model tracking it).
        cur_req = "R3";
        for (int k = 0; k < M; k++) stream_elem(W'($urandom), 1'b0, '0, 0);
        for (int k = 0; k < N; k++) load_elem(row_m[k], 0);
        for (int k = 0; k < (N - 1) * M; k++) stream_elem(W'($urandom), 1'($urandom), W'($urandom), 0);

        // R1: reset in the middle of a pass, then a clean pass.
        cur_req = "R1";
        for (int k = 0; k < M + 1; k++) stream_elem(W'($urandom), 1'b0, '0, 0);
        do_reset();
        run_pass(0, 0);

        // Random mix.
        cur_req = "R4";
        for (int p = 0; p < 40; p++) begin
            if ($urandom % 3 == 0) begin
                int nl = int'($urandom % (2 * N + 1));
                for (int k = 0; k < nl; k++) load_elem(W'($urandom), 4);
            end
            run_pass(int'($urandom % 3), 4);
        end

        idle_junk(); idle_junk();
        finish_run();
    end

endmodule